// File: doc/BRIEF.md
# Hardwired Multi-Cycle Instruction Controller

This block fetches, decodes and executes a sixteen-operation instruction set on an 8-bit datapath. It has four general registers, a stack pointer, an address register, a program counter and a zero flag. A finite-state controller sequences every instruction. It reads the 16-bit instruction from byte-wide memory in two reads, low byte first. It then steps through one or two execute states, and it pulses `instr_done` in the last execute state before it returns to fetch. The datapath registers and the ALU sit in the same top module. Memory is external.

Memory is reached through plain control pins with no handshake. A read issued in one cycle (`mem_rd` high with `mem_addr`) must return its byte on `mem_rdata` in the next cycle. A write (`mem_wr` high) takes effect at the clock edge that ends the cycle. The memory can never stall the controller, so there is no back-pressure. Instructions in the register form name a destination and two sources. Instructions in the address form carry a mode bit, a 2-bit register select and an 8-bit field. The instruction layout assumes the default `DW` of 8.

Top module: `hwc_core`

## Requirements
- R1: Reset (active-low `rst_n`) sets PC, R1 to R4, AR and the zero flag to 0 and sets SP to 0xFF. A fetch drives `mem_rd` with `mem_addr`=PC and loads that byte into IR[7:0]. In the next cycle it reads PC+1 into IR[15:8]. PC ends 2 higher.
- R2: The opcode is IR[15:12]: 0 AND, 1 OR, 2 NOT, 3 ADD, 4 SUB, 5 LSR, 6 LSL, 7 INC, 8 DEC. The result goes to the register coded in IR[10:8], with source 1 coded in IR[6:4] and source 2 in IR[2:0]. LSR and LSL shift one place and fill with 0. Arithmetic wraps modulo 256.
- R3: The zero flag is updated only by opcodes 0 to 8, and it becomes 1 exactly when their 8-bit result is 0. Every other opcode leaves it unchanged.
- R4: A 3-bit register code selects 0 R1, 1 R2, 2 R3, 3 R4, 4 SP, 5 AR, and 6 or 7 the PC. Bits IR[11], IR[7] and IR[3] are ignored. Reading the PC gives the address after the current instruction. Writing it redirects the next fetch. Opcode 0xB (MOV) copies source 1 to the destination.
- R5: Opcode 0xC (LD) writes the register selected by IR[9:8] with IR[7:0] when IR[10]=0, or with M[AR] when IR[10]=1.
- R6: Opcode 0xD (ST) writes the register selected by IR[9:8] to M[AR], whatever the value of IR[10].
- R7: Opcode 0x9 (BRA) loads PC with IR[7:0]. Opcode 0xA (BNE) does the same only when the zero flag is 0.
- R8: Opcode 0xE (PUL) increments SP and then loads the register selected by IR[9:8] from M[SP], using the new SP.
- R9: Opcode 0xF (PSH) writes the register selected by IR[9:8] to M[SP] and then decrements SP.
- R10: An instruction takes 3 fetch cycles plus 1 execute cycle, or plus 2 for LD with IR[10]=1, PUL and PSH. `instr_done` is high for exactly the last execute cycle, and a fetch read follows in the next cycle.
- R11: `mem_rd` and `mem_wr` are never high together. Memory reads assume a fixed one-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | 8 | Byte returned one cycle after a read |
| mem_addr | output | 8 | Memory address (PC, AR, SP or SP+1) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Byte to write |
| instr_done | output | 1 | High in the last execute cycle of each instruction |

## Verification
The corner cases the bench goes after are the following.

- Register codes 6 and 7 used as a destination. A design that wrote them somewhere other than the PC would fetch from the wrong address.
- The zero flag surviving MOV, loads and stack operations. A design that cleared or updated it there would take or skip BNE wrongly.
- The order of stack steps, with SP wrapping around 0xFF and 0x00. Incrementing or decrementing at the wrong moment would push to or pull from an address one off.
- The ignored bits IR[11], IR[10] on ST, and bit 3 of each register code. A design that honoured them would write the wrong register or address.

A directed loop program checks its stored sums. Random memory images are then run as programs against an instruction-level model, comparing every write, every next fetch address and every instruction length.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_OR  = 4'h1, OP_NOT = 4'h2, OP_ADD = 4'h3,
    OP_SUB = 4'h4, OP_LSR = 4'h5, OP_LSL = 4'h6, OP_INC = 4'h7,
    OP_DEC = 4'h8, OP_BRA = 4'h9, OP_BNE = 4'hA, OP_MOV = 4'hB,
    OP_LD  = 4'hC, OP_ST  = 4'hD, OP_PUL = 4'hE, OP_PSH = 4'hF
  } op_e;

  typedef enum logic [2:0] {
    ST_FLO, ST_FHI, ST_FWT, ST_EX1, ST_EX2
  } st_e;

  typedef enum logic [1:0] {
    WS_ALU, WS_IMM, WS_MEM
  } wsrc_e;

  typedef enum logic [1:0] {
    MA_PC, MA_AR, MA_SP, MA_SPP
  } masrc_e;

  typedef struct packed {
    logic       ir_lo_ld;
    logic       ir_hi_ld;
    logic       pc_inc;
    logic       we;
    logic [2:0] wsel;
    wsrc_e      wsrc;
    logic       sp_inc;
    logic       sp_dec;
    logic       z_ld;
    logic       mem_rd;
    logic       mem_wr;
    masrc_e     masrc;
    logic       done;
  } ctl_t;

  localparam logic [2:0] RC_SP = 3'd4;
  localparam logic [2:0] RC_AR = 3'd5;
  localparam logic [2:0] RC_PC = 3'd6;

endpackage

// File: rtl/hwc_alu.sv
module hwc_alu
  import hwc_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_NOT:  y = ~a;
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_LSR:  y = {1'b0, a[DW-1:1]};
      OP_LSL:  y = {a[DW-2:0], 1'b0};
      OP_INC:  y = a + ONE;
      OP_DEC:  y = a - ONE;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/hwc_regs.sv
module hwc_regs
  import hwc_pkg::*;
#(
  parameter int            DW     = 8,
  parameter logic [DW-1:0] SP_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    rd_a,
  input  logic [2:0]    rd_b,
  input  logic [2:0]    rd_c,
  input  logic          we,
  input  logic [2:0]    wsel,
  input  logic [DW-1:0] wdata,
  input  logic          pc_inc,
  input  logic          sp_inc,
  input  logic          sp_dec,
  input  logic          z_ld,
  input  logic          z_in,
  output logic [DW-1:0] q_a,
  output logic [DW-1:0] q_b,
  output logic [DW-1:0] q_c,
  output logic [DW-1:0] pc,
  output logic [DW-1:0] sp,
  output logic [DW-1:0] ar,
  output logic          zf
);
  localparam int            NGP = 4;
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [NGP-1:0][DW-1:0] gp_v;
  logic [DW-1:0] pc_q, sp_q, ar_q;
  logic          z_q;

  for (genvar g = 0; g < NGP; g++) begin : g_gp
    logic [DW-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      r_q <= '0;
      else if (we && wsel == 3'(g))    r_q <= wdata;
    end
    assign gp_v[g] = r_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pc_q <= '0;
    else if (we && wsel[2:1] == 2'b11) pc_q <= wdata;
    else if (pc_inc)                  pc_q <= pc_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   sp_q <= SP_RST;
    else if (we && wsel == RC_SP) sp_q <= wdata;
    else if (sp_inc)              sp_q <= sp_q + ONE;
    else if (sp_dec)              sp_q <= sp_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ar_q <= '0;
    else if (we && wsel == RC_AR) ar_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    z_q <= 1'b0;
    else if (z_ld) z_q <= z_in;
  end

  function automatic logic [DW-1:0] pick(input logic [2:0] code);
    case (code)
      3'd0, 3'd1, 3'd2, 3'd3: pick = gp_v[code[1:0]];
      RC_SP:                  pick = sp_q;
      RC_AR:                  pick = ar_q;
      default:                pick = pc_q;
    endcase
  endfunction

  assign q_a = pick(rd_a);
  assign q_b = pick(rd_b);
  assign q_c = pick(rd_c);
  assign pc  = pc_q;
  assign sp  = sp_q;
  assign ar  = ar_q;
  assign zf  = z_q;
endmodule

// File: rtl/hwc_fsm.sv
module hwc_fsm
  import hwc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] ir,
  input  logic        zf,
  output ctl_t        ctl,
  output st_e         st
);
  st_e st_q, st_d;
  op_e op;
  logic [2:0] rsel3;

  assign op    = op_e'(ir[15:12]);
  assign rsel3 = {1'b0, ir[9:8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_FLO;
    else        st_q <= st_d;
  end

  always_comb begin
    ctl       = '0;
    ctl.wsrc  = WS_ALU;
    ctl.masrc = MA_PC;
    st_d      = st_q;
    case (st_q)
      ST_FLO: begin
        ctl.mem_rd = 1'b1;
        ctl.pc_inc = 1'b1;
        st_d       = ST_FHI;
      end
      ST_FHI: begin
        ctl.mem_rd   = 1'b1;
        ctl.pc_inc   = 1'b1;
        ctl.ir_lo_ld = 1'b1;
        st_d         = ST_FWT;
      end
      ST_FWT: begin
        ctl.ir_hi_ld = 1'b1;
        st_d         = ST_EX1;
      end
      ST_EX1: begin
        ctl.done = 1'b1;
        st_d     = ST_FLO;
        case (op)
          OP_AND, OP_OR, OP_NOT, OP_ADD, OP_SUB,
          OP_LSR, OP_LSL, OP_INC, OP_DEC: begin
            ctl.we   = 1'b1;
            ctl.wsel = ir[10:8];
            ctl.z_ld = 1'b1;
          end
          OP_MOV: begin
            ctl.we   = 1'b1;
            ctl.wsel = ir[10:8];
          end
          OP_BRA, OP_BNE: begin
            ctl.we   = (op == OP_BRA) || !zf;
            ctl.wsel = RC_PC;
            ctl.wsrc = WS_IMM;
          end
          OP_LD: begin
            ctl.wsel = rsel3;
            if (ir[10]) begin
              ctl.mem_rd = 1'b1;
              ctl.masrc  = MA_AR;
              ctl.done   = 1'b0;
              st_d       = ST_EX2;
            end else begin
              ctl.we   = 1'b1;
              ctl.wsrc = WS_IMM;
            end
          end
          OP_ST: begin
            ctl.mem_wr = 1'b1;
            ctl.masrc  = MA_AR;
          end
          OP_PUL: begin
            ctl.sp_inc = 1'b1;
            ctl.mem_rd = 1'b1;
            ctl.masrc  = MA_SPP;
            ctl.done   = 1'b0;
            st_d       = ST_EX2;
          end
          OP_PSH: begin
            ctl.mem_wr = 1'b1;
            ctl.masrc  = MA_SP;
            ctl.done   = 1'b0;
            st_d       = ST_EX2;
          end
          default: ;
        endcase
      end
      ST_EX2: begin
        ctl.done = 1'b1;
        st_d     = ST_FLO;
        case (op)
          OP_LD, OP_PUL: begin
            ctl.we   = 1'b1;
            ctl.wsel = rsel3;
            ctl.wsrc = WS_MEM;
          end
          OP_PSH: ctl.sp_dec = 1'b1;
          default: ;
        endcase
      end
      default: st_d = ST_FLO;
    endcase
  end

  assign st = st_q;
endmodule

// File: rtl/hwc_core.sv
module hwc_core
  import hwc_pkg::*;
#(
  parameter int            DW     = 8,
  parameter logic [DW-1:0] SP_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic          instr_done
);
  localparam int            IW  = 2 * DW;
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [IW-1:0] ir_q;
  ctl_t          ctl;
  st_e           st_w;
  logic          zf_w;
  logic [DW-1:0] src_a, src_b, src_c, alu_y, wdata;
  logic [DW-1:0] pc_w, sp_w, ar_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= '0;
    end else begin
      if (ctl.ir_lo_ld) ir_q[DW-1:0]  <= mem_rdata;
      if (ctl.ir_hi_ld) ir_q[IW-1:DW] <= mem_rdata;
    end
  end

  hwc_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .ir    (ir_q[15:0]),
    .zf    (zf_w),
    .ctl   (ctl),
    .st    (st_w)
  );

  hwc_alu #(.DW(DW)) u_alu (
    .op (op_e'(ir_q[15:12])),
    .a  (src_a),
    .b  (src_b),
    .y  (alu_y)
  );

  always_comb begin
    case (ctl.wsrc)
      WS_IMM:  wdata = ir_q[DW-1:0];
      WS_MEM:  wdata = mem_rdata;
      default: wdata = alu_y;
    endcase
  end

  hwc_regs #(.DW(DW), .SP_RST(SP_RST)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_a   (ir_q[6:4]),
    .rd_b   (ir_q[2:0]),
    .rd_c   ({1'b0, ir_q[9:8]}),
    .we     (ctl.we),
    .wsel   (ctl.wsel),
    .wdata  (wdata),
    .pc_inc (ctl.pc_inc),
    .sp_inc (ctl.sp_inc),
    .sp_dec (ctl.sp_dec),
    .z_ld   (ctl.z_ld),
    .z_in   (alu_y == '0),
    .q_a    (src_a),
    .q_b    (src_b),
    .q_c    (src_c),
    .pc     (pc_w),
    .sp     (sp_w),
    .ar     (ar_w),
    .zf     (zf_w)
  );

  always_comb begin
    case (ctl.masrc)
      MA_AR:   mem_addr = ar_w;
      MA_SP:   mem_addr = sp_w;
      MA_SPP:  mem_addr = sp_w + ONE;
      default: mem_addr = pc_w;
    endcase
  end

  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign mem_wdata  = src_c;
  assign instr_done = ctl.done;
endmodule

// File: rtl/hwc_core_chk.sv
module hwc_core_chk
  import hwc_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [DW-1:0] mem_addr,
  input logic          instr_done,
  input st_e           st,
  input logic [3:0]    op,
  input logic          zf
);
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R11

  AST_DONE_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> (mem_rd && !mem_wr && st == ST_FLO)); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> !instr_done); // R10

  AST_NO_DONE_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_EX1 && st != ST_EX2) |-> !instr_done); // R10

  AST_FETCH_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FLO) |=> (mem_rd && mem_addr == $past(mem_addr) + DW'(1))); // R1

  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(st == ST_EX1 && op <= 4'h8) |=> $stable(zf)); // R3
endmodule

bind hwc_core hwc_core_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_addr   (mem_addr),
  .instr_done (instr_done),
  .st         (st_w),
  .op         (ir_q[15:12]),
  .zf         (zf_w)
);

// File: tb/hwc_core_tb.sv
`timescale 1ns/1ps
module hwc_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_rdata;
  logic [7:0] mem_addr, mem_wdata;
  logic       mem_rd, mem_wr, instr_done;

  always #2 clk = ~clk;

  hwc_core u_dut (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .instr_done(instr_done)
  );

  logic [7:0] dmem [256];
  logic [7:0] mmem [256];
  logic       copy_req = 1'b0;
  int unsigned wr_cnt = 0;
  logic [7:0] wr_a = '0, wr_d = '0;
  longint     cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (copy_req) begin
      for (int i = 0; i < 256; i++) dmem[i] <= mmem[i];
    end else begin
      if (mem_rd) mem_rdata <= dmem[mem_addr];
      if (mem_wr) begin
        dmem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
        wr_a   <= mem_addr;
        wr_d   <= mem_wdata;
      end
    end
  end

  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string tg, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tg, what, act, exp);
    end
  endtask

  // instruction-level model
  logic [7:0] m_r [4];
  logic [7:0] m_sp, m_ar, m_pc;
  logic       m_z;

  function automatic logic [7:0] m_rd(input logic [2:0] c);
    case (c)
      3'd0, 3'd1, 3'd2, 3'd3: return m_r[c[1:0]];
      3'd4: return m_sp;
      3'd5: return m_ar;
      default: return m_pc;
    endcase
  endfunction

  task automatic m_wr(input logic [2:0] c, input logic [7:0] v);
    case (c)
      3'd0, 3'd1, 3'd2, 3'd3: m_r[c[1:0]] = v;
      3'd4: m_sp = v;
      3'd5: m_ar = v;
      default: m_pc = v;
    endcase
  endtask

  task automatic m_reset();
    for (int i = 0; i < 4; i++) m_r[i] = '0;
    m_sp = 8'hFF; m_ar = '0; m_pc = '0; m_z = 1'b0;
  endtask

  task automatic m_step(output bit ew, output logic [7:0] ea, output logic [7:0] ed,
                        output int nc, output string tg);
    logic [15:0] ir;
    logic [7:0]  a, b, y, imm;
    logic [2:0]  rs;
    ir = {mmem[8'(m_pc + 8'd1)], mmem[m_pc]};
    m_pc = m_pc + 8'd2;
    a = m_rd(ir[6:4]); b = m_rd(ir[2:0]); imm = ir[7:0]; rs = {1'b0, ir[9:8]};
    ew = 1'b0; ea = '0; ed = '0; nc = 4; y = '0; tg = "R1";
    case (ir[15:12])
      4'h0: y = a & b;
      4'h1: y = a | b;
      4'h2: y = ~a;
      4'h3: y = a + b;
      4'h4: y = a - b;
      4'h5: y = a >> 1;
      4'h6: y = a << 1;
      4'h7: y = a + 8'd1;
      4'h8: y = a - 8'd1;
      default: ;
    endcase
    case (ir[15:12])
      4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8: begin
        m_wr(ir[10:8], y); m_z = (y == 8'h00); tg = "R2 R3 R4";
      end
      4'h9: begin m_pc = imm; tg = "R7"; end
      4'hA: begin if (!m_z) m_pc = imm; tg = "R3 R7"; end
      4'hB: begin m_wr(ir[10:8], a); tg = "R4"; end
      4'hC: begin
        tg = "R5";
        if (ir[10]) begin m_wr(rs, mmem[m_ar]); nc = 5; end
        else m_wr(rs, imm);
      end
      4'hD: begin
        ew = 1'b1; ea = m_ar; ed = m_rd(rs); mmem[m_ar] = ed; tg = "R6";
      end
      4'hE: begin
        m_sp = m_sp + 8'd1; m_wr(rs, mmem[m_sp]); nc = 5; tg = "R8";
      end
      default: begin
        ew = 1'b1; ea = m_sp; ed = m_rd(rs); mmem[m_sp] = ed;
        m_sp = m_sp - 8'd1; nc = 5; tg = "R9";
      end
    endcase
  endtask

  int unsigned wr_prev;
  longint      done_prev;
  bit          have_prev;

  task automatic do_reset();
    rst_n = 1'b0;
    copy_req = 1'b1;
    @(posedge clk); @(posedge clk);
    copy_req = 1'b0;
    m_reset();
    @(negedge clk);
    chk(mem_rd == 1'b1 && mem_addr == 8'h00, "R1", "reset fetch address", mem_addr, 0);
    chk(mem_wr == 1'b0 && instr_done == 1'b0, "R1", "reset strobes",
        {mem_wr, instr_done}, 0);
    wr_prev = wr_cnt;
    have_prev = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic run_instrs(input int n);
    bit ew; logic [7:0] ea, ed; int nc; string tg;
    longint dc;
    for (int k = 0; k < n; k++) begin
      int w = 0;
      @(negedge clk);
      while (!instr_done && w < 16) begin @(negedge clk); w++; end
      if (!instr_done) begin
        chk(1'b0, "R10", "instr_done never rose", 0, 1);
        return;
      end
      dc = cyc;
      @(negedge clk);
      m_step(ew, ea, ed, nc, tg);
      if (have_prev) chk(dc - done_prev == longint'(nc), "R10", "instruction cycles",
                         dc - done_prev, nc);
      chk(wr_cnt - wr_prev == 32'(ew), tg, "write count", wr_cnt - wr_prev, ew);
      if (ew) begin
        chk(wr_a == ea, tg, "write address", wr_a, ea);
        chk(wr_d == ed, tg, "write data", wr_d, ed);
      end
      chk(mem_rd && !mem_wr && mem_addr == m_pc, tg, "next fetch address", mem_addr, m_pc);
      wr_prev = wr_cnt;
      done_prev = dc;
      have_prev = 1'b1;
    end
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] w);
    mmem[a] = w[7:0];
    mmem[8'(a + 8'd1)] = w[15:8];
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd7321);
    for (int i = 0; i < 256; i++) mmem[i] = '0;
    // directed: summing loop, stack, PC destination, BNE not taken
    put(8'h00, 16'hC005);  put(8'h02, 16'hC100);  put(8'h04, 16'hC290);
    put(8'h06, 16'hB520);  put(8'h08, 16'hC600);  put(8'h0A, 16'h3112);
    put(8'h0C, 16'h7550);  put(8'h0E, 16'h8000);  put(8'h10, 16'hA008);
    put(8'h12, 16'hD100);  put(8'h14, 16'hF100);  put(8'h16, 16'hE300);
    put(8'h18, 16'hC020);  put(8'h1A, 16'hB600);  put(8'h1C, 16'hC300);
    put(8'h1E, 16'hC300);  put(8'h20, 16'h4000);  put(8'h22, 16'hA01C);
    put(8'h24, 16'hC240);  put(8'h26, 16'hB520);  put(8'h28, 16'hD300);
    put(8'h2A, 16'h902A);
    mmem[8'h90] = 8'h11; mmem[8'h91] = 8'h22; mmem[8'h92] = 8'h33;
    mmem[8'h93] = 8'h44; mmem[8'h94] = 8'h55;
    do_reset();
    run_instrs(45);
    chk(dmem[8'h95] == 8'hFF, "R5 R6", "loop sum stored at AR", dmem[8'h95], 8'hFF);
    chk(dmem[8'hFF] == 8'hFF, "R9", "push to reset SP", dmem[8'hFF], 8'hFF);
    chk(dmem[8'h40] == 8'hFF, "R4 R7 R8", "pulled value after PC jump", dmem[8'h40], 8'hFF);
    // random memory images run as programs
    for (int rnd = 0; rnd < 4; rnd++) begin
      for (int i = 0; i < 256; i++) mmem[i] = 8'($urandom);
      do_reset();
      run_instrs(800);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R10 watchdog expired: actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule